// File: doc/BRIEF.md
# Over-Current Pulse-Skip and Latch Sequencer

This block supervises the high-side switch of a synchronous buck converter cycle by cycle. It runs on a fast system clock. A one-clock strobe marks the start of each switching period. At every strobe it looks at the current-limit-detected flag from the analog comparator.

When the flag is seen while the converter is running normally, the high-side drive is blocked for the current switching period and for the eight periods that follow. The block then opens an eight-period watch window, periods 9 to 16 counted from the detection. If the flag shows up again at any period start inside that window, a shutdown fault is latched for the supervisor, and the high-side drive stays blocked until enable is dropped. If the window passes with no detection, the block goes back to normal running.

The same block also raises a duty-cycle clamp request after an output excursion that lasts for two full switching periods. The request is given only while forced-PWM operation is selected.

Top module: `ocp_skip_seq`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it is released, `hs_inhibit`, `oc_fault` and `clamp_en` are all 0.
- R2: When `ilim_det` is 1 at a `sw_tick` while the block is running normally, `hs_inhibit` goes to 1 one clock after that tick. It stays 1 for that period and for the following eight periods. It returns to 0 one clock after the ninth tick that follows the detection.
- R3: A value of 1 on `ilim_det` at any of the eight ticks that follow the detection tick is ignored. It neither restarts the skip window nor sets `oc_fault`.
- R4: When `ilim_det` is 1 at any of the ticks that start periods 9 through 16 after the detection (the 9th to the 16th tick after it), `oc_fault` goes to 1 one clock after that tick.
- R5: When no detection occurs at the ticks of periods 9 through 16, `oc_fault` stays 0 and `hs_inhibit` stays 0, and the block returns to normal running. A detection at the 17th tick then opens a fresh skip window and does not set a fault.
- R6: Once set, `oc_fault` stays 1, and `hs_inhibit` stays 1 with it, for as long as `en` is high. One clock after `en` is low, both are 0. While `en` is low, detections are ignored.
- R7: With `fpwm` high, `clamp_en` goes to 1 one clock after the third consecutive tick at which `excursion` is 1. It goes back to 0 one clock after a tick at which `excursion` is 0.
- R8: While `fpwm` is low, `clamp_en` is 0 whatever the excursion history. The excursion count keeps running, so `clamp_en` follows at once when `fpwm` is raised again.
- R9: Between ticks, `ilim_det` has no effect on `hs_inhibit` or `oc_fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; puts the block in normal running and clears the fault |
| en | input | 1 | Converter enable; low clears the fault and holds the block idle |
| sw_tick | input | 1 | One-clock strobe at the start of each switching period |
| ilim_det | input | 1 | Current-limit-detected flag, sampled at `sw_tick` |
| excursion | input | 1 | Severe output excursion flag, sampled at `sw_tick` |
| fpwm | input | 1 | Forced-PWM select; low disables the duty clamp |
| hs_inhibit | output | 1 | Blocks the high-side drive for the current period |
| oc_fault | output | 1 | Latched over-current shutdown fault |
| clamp_en | output | 1 | Duty-cycle clamp request |

## Verification
The detection patterns are chosen to separate neighbouring window positions. A single detection followed by silence shows where the skip window ends and that the block recovers. Detections repeated through the skip window show that these are ignored and do not stretch the window. Detections placed exactly on the 9th and on the 16th tick pin both edges of the watch window. A detection on the 17th tick must open a new window rather than latch, so a window that is off by one in either direction shows up. Excursion runs of two and three ticks, with forced-PWM toggled, separate the clamp delay from the forced-PWM gating.

// File: rtl/ocp_pkg.sv
`timescale 1ns/1ps
package ocp_pkg;

  typedef enum logic [1:0] {
    SQ_RUN   = 2'd0,
    SQ_SKIP  = 2'd1,
    SQ_WATCH = 2'd2,
    SQ_TRIP  = 2'd3
  } seq_state_t;

  // period index at which the skip window hands over to the watch window
  function automatic logic skip_ends(input int unsigned idx, input int unsigned skip_len);
    return idx == skip_len;
  endfunction

  // period index of the final watch period
  function automatic logic watch_ends(input int unsigned idx, input int unsigned skip_len,
                                      input int unsigned watch_len);
    return idx == (skip_len + watch_len);
  endfunction

  // clamp is due once the excursion has been seen on more than dly+0 ticks
  function automatic logic clamp_due(input int unsigned seen, input int unsigned dly);
    return seen > dly;
  endfunction

endpackage

// File: rtl/ocp_window_fsm.sv
`timescale 1ns/1ps
module ocp_window_fsm
  import ocp_pkg::*;
#(
  parameter int unsigned SKIP_LEN  = 8,
  parameter int unsigned WATCH_LEN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       sw_tick,
  input  logic       ilim_det,
  output seq_state_t state,
  output logic       win_open,
  output logic       fault_set
);
  localparam int unsigned SPAN  = SKIP_LEN + WATCH_LEN;
  localparam int unsigned CNT_W = $clog2(SPAN + 1);

  seq_state_t       st_q, st_d;
  logic [CNT_W-1:0] idx_q, idx_d;

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    win_open  = 1'b0;
    fault_set = 1'b0;
    if (!en) begin
      st_d  = SQ_RUN;
      idx_d = '0;
    end else if (sw_tick) begin
      case (st_q)
        SQ_RUN: begin
          if (ilim_det) begin
            st_d     = SQ_SKIP;
            idx_d    = '0;
            win_open = 1'b1;
          end
        end
        SQ_SKIP: begin
          idx_d = idx_q + 1'b1;
          if (skip_ends(32'(idx_q), SKIP_LEN)) begin
            if (ilim_det) begin
              st_d      = SQ_TRIP;
              fault_set = 1'b1;
            end else begin
              st_d = SQ_WATCH;
            end
          end
        end
        SQ_WATCH: begin
          if (watch_ends(32'(idx_q), SKIP_LEN, WATCH_LEN)) begin
            idx_d = '0;
            if (ilim_det) begin
              st_d     = SQ_SKIP;
              win_open = 1'b1;
            end else begin
              st_d = SQ_RUN;
            end
          end else if (ilim_det) begin
            st_d      = SQ_TRIP;
            fault_set = 1'b1;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
        default: begin
          st_d = SQ_TRIP;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_RUN;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign state = st_q;

endmodule

// File: rtl/excursion_clamp.sv
`timescale 1ns/1ps
module excursion_clamp
  import ocp_pkg::*;
#(
  parameter int unsigned CLAMP_DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sw_tick,
  input  logic excursion,
  input  logic fpwm,
  output logic clamp_en
);
  localparam int unsigned SAT   = CLAMP_DLY + 1;
  localparam int unsigned RUN_W = $clog2(SAT + 1);

  logic [RUN_W-1:0] run_q;
  logic             due;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!en) begin
      run_q <= '0;
    end else if (sw_tick) begin
      if (!excursion)
        run_q <= '0;
      else if (32'(run_q) < SAT)
        run_q <= run_q + 1'b1;
    end
  end

  assign due      = clamp_due(32'(run_q), CLAMP_DLY);
  assign clamp_en = due & fpwm;

endmodule

// File: rtl/ocp_skip_seq.sv
`timescale 1ns/1ps
module ocp_skip_seq
  import ocp_pkg::*;
#(
  parameter int unsigned SKIP_LEN  = 8,
  parameter int unsigned WATCH_LEN = 8,
  parameter int unsigned CLAMP_DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sw_tick,
  input  logic ilim_det,
  input  logic excursion,
  input  logic fpwm,
  output logic hs_inhibit,
  output logic oc_fault,
  output logic clamp_en
);
  seq_state_t seq_state;
  logic       win_open;
  logic       fault_set;

  ocp_window_fsm #(
    .SKIP_LEN (SKIP_LEN),
    .WATCH_LEN(WATCH_LEN)
  ) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .sw_tick  (sw_tick),
    .ilim_det (ilim_det),
    .state    (seq_state),
    .win_open (win_open),
    .fault_set(fault_set)
  );

  excursion_clamp #(
    .CLAMP_DLY(CLAMP_DLY)
  ) u_clamp (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .sw_tick  (sw_tick),
    .excursion(excursion),
    .fpwm     (fpwm),
    .clamp_en (clamp_en)
  );

  assign oc_fault   = (seq_state == SQ_TRIP);
  assign hs_inhibit = (seq_state == SQ_SKIP) || (seq_state == SQ_TRIP);

endmodule

// File: rtl/ocp_skip_seq_chk.sv
`timescale 1ns/1ps
module ocp_skip_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic sw_tick,
  input logic ilim_det,
  input logic hs_inhibit,
  input logic oc_fault,
  input logic clamp_en,
  input logic win_open,
  input logic fault_set
);

  AST_WINDOW_BLOCKS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |=> (hs_inhibit && !oc_fault)); // R2

  AST_TRIP_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oc_fault) |-> $past(sw_tick && ilim_det)); // R4

  AST_TRIP_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    fault_set |=> oc_fault); // R4

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_fault && en) |=> (oc_fault && hs_inhibit)); // R6

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!oc_fault && !hs_inhibit && !clamp_en)); // R6

  AST_QUIET_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !sw_tick) |=> ($stable(hs_inhibit) && $stable(oc_fault))); // R9

endmodule

bind ocp_skip_seq ocp_skip_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .sw_tick   (sw_tick),
  .ilim_det  (ilim_det),
  .hs_inhibit(hs_inhibit),
  .oc_fault  (oc_fault),
  .clamp_en  (clamp_en),
  .win_open  (win_open),
  .fault_set (fault_set)
);

// File: tb/sim_ocp_skip_seq.sv
`timescale 1ns/1ps
module sim_ocp_skip_seq;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic sw_tick = 1'b0;
  logic ilim_det = 1'b0;
  logic excursion = 1'b0;
  logic fpwm = 1'b1;
  logic hs_inhibit, oc_fault, clamp_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ocp_skip_seq u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .sw_tick(sw_tick), .ilim_det(ilim_det),
    .excursion(excursion), .fpwm(fpwm),
    .hs_inhibit(hs_inhibit), .oc_fault(oc_fault), .clamp_en(clamp_en)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // one switching period: strobe for one clock, then a few quiet clocks
  task automatic do_tick(input logic lim, input logic exc);
    @(negedge clk);
    sw_tick = 1'b1; ilim_det = lim; excursion = exc;
    @(negedge clk);
    sw_tick = 1'b0; ilim_det = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic quiet_ticks(input int n);
    for (int i = 0; i < n; i++) do_tick(1'b0, 1'b0);
  endtask

  task automatic cycle_enable();
    @(negedge clk); en = 1'b0;
    repeat (2) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1", "inhibit in reset", hs_inhibit, 1'b0);
    check("R1", "fault in reset", oc_fault, 1'b0);
    check("R1", "clamp in reset", clamp_en, 1'b0);
    @(negedge clk); rst_n = 1'b1; en = 1'b1;
    @(negedge clk);
    check("R1", "inhibit after reset", hs_inhibit, 1'b0);
    check("R1", "fault after reset", oc_fault, 1'b0);
  endtask

  task automatic t_skip_recover();
    do_tick(1'b1, 1'b0);
    check("R2", "inhibit at detection", hs_inhibit, 1'b1);
    for (int k = 1; k <= 8; k++) begin
      do_tick(1'b0, 1'b0);
      check("R2", $sformatf("inhibit period %0d", k), hs_inhibit, 1'b1);
    end
    do_tick(1'b0, 1'b0);
    check("R2", "inhibit released period 9", hs_inhibit, 1'b0);
    for (int k = 10; k <= 16; k++) begin
      do_tick(1'b0, 1'b0);
      check("R5", $sformatf("no fault period %0d", k), oc_fault | hs_inhibit, 1'b0);
    end
    do_tick(1'b0, 1'b0);
    check("R5", "running after window", oc_fault | hs_inhibit, 1'b0);
  endtask

  task automatic t_ignore_in_skip();
    do_tick(1'b1, 1'b0);
    for (int k = 1; k <= 8; k++) do_tick(1'b1, 1'b0);
    check("R3", "no fault from skip detections", oc_fault, 1'b0);
    do_tick(1'b0, 1'b0);
    check("R3", "window not restarted", hs_inhibit, 1'b0);
    quiet_ticks(7);
    do_tick(1'b1, 1'b0);
    check("R5", "period 17 opens new window", hs_inhibit, 1'b1);
    check("R5", "period 17 no fault", oc_fault, 1'b0);
    quiet_ticks(17);
    check("R5", "second window clean", oc_fault | hs_inhibit, 1'b0);
  endtask

  task automatic t_trip_first();
    do_tick(1'b1, 1'b0);
    quiet_ticks(8);
    do_tick(1'b1, 1'b0);
    check("R4", "fault at period 9", oc_fault, 1'b1);
    check("R6", "drive blocked in fault", hs_inhibit, 1'b1);
    quiet_ticks(20);
    check("R6", "fault sticky", oc_fault, 1'b1);
    cycle_enable();
    check("R6", "fault cleared by enable", oc_fault, 1'b0);
    check("R6", "drive released by enable", hs_inhibit, 1'b0);
  endtask

  task automatic t_trip_last();
    do_tick(1'b1, 1'b0);
    quiet_ticks(15);
    check("R4", "no fault before period 16", oc_fault, 1'b0);
    do_tick(1'b1, 1'b0);
    check("R4", "fault at period 16", oc_fault, 1'b1);
    cycle_enable();
    check("R6", "fault cleared again", oc_fault, 1'b0);
  endtask

  task automatic t_no_tick();
    @(negedge clk); ilim_det = 1'b1;
    repeat (6) @(negedge clk);
    ilim_det = 1'b0;
    @(negedge clk);
    check("R9", "flag between ticks ignored", hs_inhibit, 1'b0);
  endtask

  task automatic t_disabled();
    @(negedge clk); en = 1'b0;
    do_tick(1'b1, 1'b0);
    check("R6", "detection ignored while disabled", hs_inhibit, 1'b0);
    @(negedge clk); en = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_clamp();
    fpwm = 1'b1;
    do_tick(1'b0, 1'b1);
    check("R7", "clamp after 1 tick", clamp_en, 1'b0);
    do_tick(1'b0, 1'b1);
    check("R7", "clamp after 2 ticks", clamp_en, 1'b0);
    do_tick(1'b0, 1'b1);
    check("R7", "clamp after 3 ticks", clamp_en, 1'b1);
    do_tick(1'b0, 1'b0);
    check("R7", "clamp dropped", clamp_en, 1'b0);
    @(negedge clk); fpwm = 1'b0;
    for (int k = 0; k < 4; k++) do_tick(1'b0, 1'b1);
    check("R8", "no clamp with fpwm low", clamp_en, 1'b0);
    @(negedge clk); fpwm = 1'b1;
    #1;
    check("R8", "clamp follows fpwm", clamp_en, 1'b1);
    do_tick(1'b0, 1'b0);
  endtask

  task automatic t_reset_fault();
    do_tick(1'b1, 1'b0);
    quiet_ticks(9);
    do_tick(1'b1, 1'b0);
    check("R4", "fault before reset", oc_fault, 1'b1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1", "reset clears fault", oc_fault, 1'b0);
    check("R1", "reset clears inhibit", hs_inhibit, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_skip_recover();
    t_ignore_in_skip();
    t_trip_first();
    t_trip_last();
    t_no_tick();
    t_disabled();
    t_clamp();
    t_reset_fault();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule